// File: doc/BRIEF.md
# Delta-Sigma Decimating Front-End

This block turns the one-bit outputs of several delta-sigma modulators into 16-bit raw sample words. The channels are split into two groups. Group A holds the low channel indices, for example the phase currents. Group B holds the remaining channels, such as supply voltage or analog inputs. Each group has its own decimation ratio, so one group can run faster at lower resolution while the other runs slower at higher resolution. Every channel has its own third-order sinc (CIC) decimator. All filters of a group run side by side and publish together on one valid strobe.

The bitstream source is configurable. In internal mode one bit arrives each system clock. In external mode a clock-mode field picks one of three options:
- drive a divided modulator clock out on the clock pins;
- sense a modulator clock on an input pin;
- use each clock pin as the one-bit feedback output of a comparator-plus-RC first-order loop.

Both the clock sampling edge and the data bit polarity are selectable. For calibration and test, host-written words can replace the group A samples, while the filtered words stay visible on a separate output.

Top module: `dsm_frontend`

## Requirements
- R1: While reset is held, `raw_o`, `smp_o`, `vld_a` and `vld_b` are all zero, and `mclk_oe` is zero when internal mode is configured.
- R2: With `cfg_ext_mod`=0, one bit per channel is taken every system clock. `vld_a` pulses for one cycle every R_A cycles. For a constant-one input, each group A word settles to R_A³.
- R3: The two groups decimate independently. `vld_b` pulses once every R_B bit periods, whatever R_A is.
- R4: All channels of a group update on the cycle their group strobe is high. Channel i sits in `raw_o[16i+15:16i]`. Channels 0..NA-1 form group A and the rest form group B.
- R5: When a channel's input has a one-density p and a period that divides the ratio R, its settled word is exactly p·R³. For example, alternating bits with R=32 give 16384.
- R6: With `cfg_dat_pol`=1, each data bit is inverted before filtering. An all-zero input then settles to R³.
- R7: `cfg_clk_mode` values: 0 = drive, 1 = sense, 2 = comparator feedback; 3 acts as 0. In drive mode (external), `mclk_oe`=1 and one bit is taken every D system clocks, where D = `cfg_clk_div` (values below 2 act as 2). The clock-pin level is high when the divider phase is at or above D/2, inverted when `cfg_clk_pol`=1. With D=3 that gives 2 of 3 cycles high, or 1 of 3 when inverted.
- R8: In sense mode (external), `mclk_oe`=0. Data is taken on the rising edge of `mclk_i` when `cfg_clk_pol`=0 and on the falling edge when it is 1. Clock and data pass through matching two-stage synchronizers.
- R9: In comparator-feedback mode (external), `mclk_oe`=1. Each comparator input is registered once every D clocks, and that raw value drives `mclk_o[i]`. The same value, XORed with `cfg_dat_pol`, enters the filter.
- R10: A write with `ext_we`=1 stores `ext_data` for group A channel `ext_idx`. With `ext_sel`=1 the stored words appear on `smp_o` while `raw_o` keeps the filtered words. With `ext_sel`=0, `smp_o` equals the group A part of `raw_o`.
- R11: A ratio setting below 2 acts as 2, and a setting above RMAX (32) acts as RMAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ext_mod | input | 1 | 0 internal bit per clock, 1 external modulator |
| cfg_clk_mode | input | 2 | External clock mode (0 drive, 1 sense, 2 comparator feedback) |
| cfg_clk_pol | input | 1 | Modulator clock polarity / sampling edge |
| cfg_dat_pol | input | 1 | Invert data bits before filtering |
| cfg_clk_div | input | DIV_W | Modulator clock divider D |
| cfg_ratio_a | input | RW | Group A decimation ratio |
| cfg_ratio_b | input | RW | Group B decimation ratio |
| ext_we | input | 1 | Write strobe for the bypass words |
| ext_idx | input | XW | Group A channel index for the write |
| ext_data | input | OUT_W | Bypass word |
| ext_sel | input | 1 | Route the bypass words to `smp_o` |
| mdat_i | input | NA+NB | Modulator data bits / comparator inputs |
| mclk_i | input | 1 | Received modulator clock |
| mclk_o | output | NA+NB | Driven clock or per-channel feedback bit |
| mclk_oe | output | 1 | Output enable for `mclk_o` |
| raw_o | output | (NA+NB)·OUT_W | Filtered words, all channels |
| smp_o | output | NA·OUT_W | Group A words after the bypass multiplexer |
| vld_a | output | 1 | Group A new-sample strobe |
| vld_b | output | 1 | Group B new-sample strobe |

## Verification
The hardest case to reach from the ports is sense mode with the edge polarity flipped. Both edges of a clean clock carry a bit per period, so the rate and value of the output alone cannot show which edge was used. The stimulus ties channel 0's data to the received clock itself. A rising-edge capture then sees only ones and a falling-edge capture sees only zeros, so the settled word is R³ or 0. A second channel toggles mid-period to confirm one bit per clock period. Rate limits are reached by writing ratios of 0 and 40 and timing the strobes.

// File: rtl/dsm_fe_pkg.sv
package dsm_fe_pkg;
   typedef enum logic [1:0] {
      CKM_DRIVE = 2'd0,
      CKM_SENSE = 2'd1,
      CKM_CMPFB = 2'd2,
      CKM_RSVD  = 2'd3
   } ckm_e;

   // accumulator width that holds rmax**order without loss
   function automatic int cic_width(input int rmax, input int order);
      return order * $clog2(rmax) + 1;
   endfunction
endpackage

// File: rtl/dsm_fe_clk.sv
module dsm_fe_clk
   import dsm_fe_pkg::*;
#(
   parameter int NCH   = 4,
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_mod,
   input  logic [1:0]       clk_mode,
   input  logic             clk_pol,
   input  logic             dat_pol,
   input  logic [DIV_W-1:0] clk_div,
   input  logic [NCH-1:0]   mdat_i,
   input  logic             mclk_i,
   output logic             bit_en,
   output logic [NCH-1:0]   bits,
   output logic [NCH-1:0]   mclk_o,
   output logic             mclk_oe
);
   if (DIV_W < 2) begin : g_chk_div
      $error("DIV_W must be at least 2");
   end

   ckm_e             mode;
   logic [DIV_W-1:0] div_eff, half, cnt;
   logic             wrap, ck_lvl, tick, sense_tick;
   logic [NCH-1:0]   ds1, ds2, fb_q, bits_q;
   logic [2:0]       cs;
   logic             en_q;

   always_comb begin
      mode    = (clk_mode == 2'd3) ? CKM_DRIVE : ckm_e'(clk_mode);
      div_eff = (clk_div < DIV_W'(2)) ? DIV_W'(2) : clk_div;
      half    = div_eff >> 1;
      wrap    = (cnt >= div_eff - 1'b1);
      ck_lvl  = (cnt >= half) ^ clk_pol;
      sense_tick = clk_pol ? (~cs[1] & cs[2]) : (cs[1] & ~cs[2]);
      if (!ext_mod)                tick = 1'b1;
      else if (mode == CKM_SENSE)  tick = sense_tick;
      else                         tick = wrap;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         cs     <= '0;
         ds1    <= '0;
         ds2    <= '0;
         fb_q   <= '0;
         bits_q <= '0;
         en_q   <= 1'b0;
      end else begin
         cnt  <= wrap ? '0 : cnt + 1'b1;
         cs   <= {cs[1:0], mclk_i};
         ds1  <= mdat_i;
         ds2  <= ds1;
         en_q <= tick;
         if (tick) begin
            fb_q   <= ds2;
            bits_q <= ds2 ^ {NCH{dat_pol}};
         end
      end
   end

   assign bit_en  = en_q;
   assign bits    = bits_q;
   assign mclk_o  = (ext_mod && mode == CKM_CMPFB) ? fb_q : {NCH{ck_lvl}};
   assign mclk_oe = ext_mod && (mode != CKM_SENSE);

   // R8: a sensed clock edge cannot repeat on the next cycle
   p_sense_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_mod && mode == CKM_SENSE && tick) |=> !tick);
   // R7: divided clock yields at most one bit per two cycles
   p_drive_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_mod && mode == CKM_DRIVE && tick) |=> !tick);
   // R9: feedback pin only moves after a capture tick
   p_fb_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_mod && mode == CKM_CMPFB && !$past(tick)) |-> $stable(fb_q));
endmodule

// File: rtl/dsm_fe_cic.sv
module dsm_fe_cic #(
   parameter int ORDER = 3,
   parameter int W     = 16,
   parameter int OUT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             bit_i,
   input  logic             dec,
   output logic [OUT_W-1:0] out_o
);
   if (ORDER < 1) begin : g_chk_order
      $error("ORDER must be at least 1");
   end

   logic [W-1:0]     acc [ORDER];
   logic [W-1:0]     dly [ORDER];
   logic [W-1:0]     cs  [ORDER+1];
   logic [OUT_W-1:0] out_q, out_sel;

   assign cs[0] = acc[ORDER-1];
   for (genvar k = 0; k < ORDER; k++) begin : g_comb
      assign cs[k+1] = cs[k] - dly[k];
   end

   if (W <= OUT_W) begin : g_wide_out
      assign out_sel = OUT_W'(cs[ORDER]);
   end else begin : g_trunc_out
      assign out_sel = cs[ORDER][W-1 -: OUT_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < ORDER; k++) begin
            acc[k] <= '0;
            dly[k] <= '0;
         end
         out_q <= '0;
      end else begin
         if (en) begin
            acc[0] <= acc[0] + W'(bit_i);
            for (int k = 1; k < ORDER; k++) acc[k] <= acc[k] + acc[k-1];
         end
         if (dec) begin
            for (int k = 0; k < ORDER; k++) dly[k] <= cs[k];
            out_q <= out_sel;
         end
      end
   end

   assign out_o = out_q;

   // R2: decimation only happens on a cycle that delivers a bit
   p_dec_with_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> en);
endmodule

// File: rtl/dsm_fe_group.sv
module dsm_fe_group #(
   parameter int NG    = 2,
   parameter int RMAX  = 32,
   parameter int RW    = 6,
   parameter int OUT_W = 16,
   parameter int ORDER = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic [NG-1:0]       bits_i,
   input  logic [RW-1:0]       ratio_i,
   output logic [NG*OUT_W-1:0] smp_o,
   output logic                vld_o
);
   localparam int W = dsm_fe_pkg::cic_width(RMAX, ORDER);

   if (RW < $clog2(RMAX + 1)) begin : g_chk_rw
      $error("RW too narrow for RMAX");
   end
   if (RMAX < 2) begin : g_chk_rmax
      $error("RMAX must be at least 2");
   end

   logic [RW-1:0] r_eff, cnt;
   logic          dec, vld_q;

   always_comb begin
      if (ratio_i < RW'(2))         r_eff = RW'(2);
      else if (ratio_i > RW'(RMAX)) r_eff = RW'(RMAX);
      else                          r_eff = ratio_i;
      dec = en && (cnt >= r_eff - 1'b1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= dec;
         if (en) cnt <= dec ? '0 : cnt + 1'b1;
      end
   end

   for (genvar g = 0; g < NG; g++) begin : g_ch
      dsm_fe_cic #(.ORDER(ORDER), .W(W), .OUT_W(OUT_W)) u_cic (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (en),
         .bit_i (bits_i[g]),
         .dec   (dec),
         .out_o (smp_o[g*OUT_W +: OUT_W])
      );
   end

   assign vld_o = vld_q;

   // R3: strobe is a single-cycle pulse since the ratio is at least 2
   p_vld_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |=> !vld_o);
   // R4: a strobe follows a cycle that carried a bit
   p_vld_after_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |-> $past(en));
endmodule

// File: rtl/dsm_frontend.sv
module dsm_frontend #(
   parameter int NA    = 2,
   parameter int NB    = 2,
   parameter int OUT_W = 16,
   parameter int RMAX  = 32,
   parameter int DIV_W = 8,
   parameter int RW    = $clog2(RMAX + 1),
   parameter int XW    = (NA > 1) ? $clog2(NA) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_ext_mod,
   input  logic [1:0]               cfg_clk_mode,
   input  logic                     cfg_clk_pol,
   input  logic                     cfg_dat_pol,
   input  logic [DIV_W-1:0]         cfg_clk_div,
   input  logic [RW-1:0]            cfg_ratio_a,
   input  logic [RW-1:0]            cfg_ratio_b,
   input  logic                     ext_we,
   input  logic [XW-1:0]            ext_idx,
   input  logic [OUT_W-1:0]         ext_data,
   input  logic                     ext_sel,
   input  logic [NA+NB-1:0]         mdat_i,
   input  logic                     mclk_i,
   output logic [NA+NB-1:0]         mclk_o,
   output logic                     mclk_oe,
   output logic [(NA+NB)*OUT_W-1:0] raw_o,
   output logic [NA*OUT_W-1:0]      smp_o,
   output logic                     vld_a,
   output logic                     vld_b
);
   localparam int NCH = NA + NB;

   if (NA < 1 || NB < 1) begin : g_chk_groups
      $error("each group needs at least one channel");
   end

   logic              bit_en;
   logic [NCH-1:0]    bits;
   logic [OUT_W-1:0]  ext_q [NA];

   dsm_fe_clk #(.NCH(NCH), .DIV_W(DIV_W)) u_clk (
      .clk      (clk),
      .rst_n    (rst_n),
      .ext_mod  (cfg_ext_mod),
      .clk_mode (cfg_clk_mode),
      .clk_pol  (cfg_clk_pol),
      .dat_pol  (cfg_dat_pol),
      .clk_div  (cfg_clk_div),
      .mdat_i   (mdat_i),
      .mclk_i   (mclk_i),
      .bit_en   (bit_en),
      .bits     (bits),
      .mclk_o   (mclk_o),
      .mclk_oe  (mclk_oe)
   );

   dsm_fe_group #(.NG(NA), .RMAX(RMAX), .RW(RW), .OUT_W(OUT_W)) u_grp_a (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (bit_en),
      .bits_i  (bits[NA-1:0]),
      .ratio_i (cfg_ratio_a),
      .smp_o   (raw_o[NA*OUT_W-1:0]),
      .vld_o   (vld_a)
   );

   dsm_fe_group #(.NG(NB), .RMAX(RMAX), .RW(RW), .OUT_W(OUT_W)) u_grp_b (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (bit_en),
      .bits_i  (bits[NCH-1:NA]),
      .ratio_i (cfg_ratio_b),
      .smp_o   (raw_o[NCH*OUT_W-1:NA*OUT_W]),
      .vld_o   (vld_b)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NA; i++) ext_q[i] <= '0;
      end else if (ext_we && (int'(ext_idx) < NA)) begin
         ext_q[ext_idx] <= ext_data;
      end
   end

   for (genvar i = 0; i < NA; i++) begin : g_mux
      assign smp_o[i*OUT_W +: OUT_W] = ext_sel ? ext_q[i] : raw_o[i*OUT_W +: OUT_W];
   end

   // R10: with bypass held and no write, the routed words do not move
   p_bypass_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_sel && $past(ext_sel) && !$past(ext_we)) |-> $stable(smp_o));
endmodule

// File: tb/dsm_frontend_test.sv
module dsm_frontend_test;
   localparam int OW = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_ext_mod = 1'b0;
   logic [1:0]  cfg_clk_mode = 2'd0;
   logic        cfg_clk_pol = 1'b0;
   logic        cfg_dat_pol = 1'b0;
   logic [7:0]  cfg_clk_div = 8'd3;
   logic [5:0]  cfg_ratio_a = 6'd16;
   logic [5:0]  cfg_ratio_b = 6'd8;
   logic        ext_we = 1'b0;
   logic [0:0]  ext_idx = 1'b0;
   logic [15:0] ext_data = '0;
   logic        ext_sel = 1'b0;
   logic [3:0]  mdat_i = '0;
   logic        mclk_i = 1'b0;
   logic [3:0]  mclk_o;
   logic        mclk_oe;
   logic [63:0] raw_o;
   logic [31:0] smp_o;
   logic        vld_a, vld_b;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int drv = 1;
   logic [3:0] cst = '0;
   int pc = 0;
   int ph = 0;
   logic tog = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dsm_frontend uut (
      .clk(clk), .rst_n(rst_n), .cfg_ext_mod(cfg_ext_mod), .cfg_clk_mode(cfg_clk_mode),
      .cfg_clk_pol(cfg_clk_pol), .cfg_dat_pol(cfg_dat_pol), .cfg_clk_div(cfg_clk_div),
      .cfg_ratio_a(cfg_ratio_a), .cfg_ratio_b(cfg_ratio_b), .ext_we(ext_we),
      .ext_idx(ext_idx), .ext_data(ext_data), .ext_sel(ext_sel), .mdat_i(mdat_i),
      .mclk_i(mclk_i), .mclk_o(mclk_o), .mclk_oe(mclk_oe), .raw_o(raw_o),
      .smp_o(smp_o), .vld_a(vld_a), .vld_b(vld_b)
   );

   // stimulus generator: 0 per-cycle patterns, 1 constants, 2 received clock
   always @(negedge clk) begin
      if (drv == 0) begin
         pc = pc + 1;
         mdat_i = {1'b0, (pc % 4) == 0, pc[0], 1'b1};
      end else if (drv == 2) begin
         ph = (ph == 5) ? 0 : ph + 1;
         mclk_i = (ph < 3);
         if (ph == 1) tog = ~tog;
         mdat_i = {1'b0, 1'b1, tog, mclk_i};
      end else begin
         mdat_i = cst;
         mclk_i = 1'b0;
      end
   end

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int raw(input int ch);
      return int'(raw_o[ch*OW +: OW]);
   endfunction

   task automatic wait_g(input bit g, input int n);
      repeat (n) begin
         @(negedge clk);
         while (!(g ? vld_b : vld_a)) @(negedge clk);
      end
   endtask

   task automatic period(input bit g, output int p);
      int t0;
      wait_g(g, 1);
      t0 = cyc;
      wait_g(g, 1);
      p = cyc - t0;
   endtask

   task automatic count_high(input int n, output int hi);
      hi = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (mclk_o[0]) hi++;
      end
   endtask

   initial begin
      #2000000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int p, hi;
      repeat (4) @(negedge clk);
      // R1 reset state
      chk("R1 raw", raw_o == '0, 1);
      chk("R1 smp", smp_o == '0, 1);
      chk("R1 vld", {vld_a, vld_b}, 0);
      chk("R1 oe", mclk_oe, 0);
      rst_n = 1'b1;

      // internal mode, per-cycle patterns
      drv = 0;
      wait_g(0, 5);
      period(0, p);  chk("R2 period A=16", p, 16);
      period(1, p);  chk("R3 period B=8", p, 8);
      wait_g(0, 1);
      chk("R4 ch0 ones", raw(0), 4096);
      chk("R4 ch1 half", raw(1), 2048);
      wait_g(1, 1);
      chk("R5 ch2 quarter", raw(2), 128);
      chk("R5 ch3 zeros", raw(3), 0);

      cfg_ratio_a = 6'd32;
      wait_g(0, 5);
      period(0, p);  chk("R5 period A=32", p, 32);
      chk("R5 ch0 R32", raw(0), 32768);
      chk("R5 ch1 R32", raw(1), 16384);
      period(1, p);  chk("R3 B unaffected", p, 8);

      cfg_ratio_a = 6'd0;
      wait_g(0, 5);
      period(0, p);  chk("R11 ratio 0 period", p, 2);
      chk("R11 ratio 0 ch0", raw(0), 8);
      chk("R11 ratio 0 ch1", raw(1), 4);

      cfg_ratio_a = 6'd40;
      wait_g(0, 5);
      period(0, p);  chk("R11 ratio 40 period", p, 32);
      chk("R11 ratio 40 ch0", raw(0), 32768);

      cfg_ratio_a = 6'd16;
      cfg_dat_pol = 1'b1;
      wait_g(0, 5);
      chk("R6 ch0 inverted", raw(0), 0);
      chk("R6 ch1 inverted", raw(1), 2048);
      wait_g(1, 5);
      chk("R6 ch2 inverted", raw(2), 384);
      chk("R6 ch3 inverted", raw(3), 512);
      cfg_dat_pol = 1'b0;
      wait_g(0, 5);

      // R10 bypass words
      ext_we = 1'b1; ext_idx = 1'b0; ext_data = 16'h1234;
      @(negedge clk);
      ext_idx = 1'b1; ext_data = 16'hBEEF;
      @(negedge clk);
      ext_we = 1'b0; ext_sel = 1'b1;
      @(negedge clk);
      chk("R10 smp ch0 bypass", int'(smp_o[15:0]), 32'h1234);
      chk("R10 smp ch1 bypass", int'(smp_o[31:16]), 32'hBEEF);
      wait_g(0, 1);
      chk("R10 raw kept", raw(0), 4096);
      chk("R10 smp still bypass", int'(smp_o[15:0]), 32'h1234);
      ext_sel = 1'b0;
      @(negedge clk);
      chk("R10 smp filtered", int'(smp_o[15:0]), 4096);
      chk("R10 smp ch1 filtered", int'(smp_o[31:16]), 2048);

      // R7 drive mode
      drv = 1; cst = 4'b0101;
      cfg_ext_mod = 1'b1; cfg_clk_mode = 2'd0; cfg_clk_pol = 1'b0; cfg_clk_div = 8'd3;
      wait_g(1, 5);
      period(1, p);  chk("R7 period B=24", p, 24);
      wait_g(0, 1);
      chk("R7 ch0", raw(0), 4096);
      chk("R7 ch1", raw(1), 0);
      wait_g(1, 1);
      chk("R7 ch2", raw(2), 512);
      chk("R7 oe", mclk_oe, 1);
      chk("R7 pins equal", (mclk_o == 4'b0000) || (mclk_o == 4'b1111), 1);
      count_high(30, hi); chk("R7 duty pol0", hi, 20);
      cfg_clk_pol = 1'b1;
      @(negedge clk);
      count_high(30, hi); chk("R7 duty pol1", hi, 10);
      cfg_clk_pol = 1'b0;
      cfg_clk_mode = 2'd3;
      wait_g(1, 3);
      period(1, p);  chk("R7 mode3 as drive", p, 24);

      // R8 sense mode
      drv = 2; cfg_clk_mode = 2'd1; cfg_clk_pol = 1'b0;
      wait_g(0, 5);
      period(0, p);  chk("R8 period A=96", p, 96);
      chk("R8 oe", mclk_oe, 0);
      chk("R8 rise ch0", raw(0), 4096);
      chk("R8 rise ch1", raw(1), 2048);
      cfg_clk_pol = 1'b1;
      wait_g(0, 5);
      chk("R8 fall ch0", raw(0), 0);
      chk("R8 fall ch1", raw(1), 2048);
      cfg_clk_pol = 1'b0;

      // R9 comparator feedback
      drv = 1; cst = 4'b0101;
      cfg_clk_mode = 2'd2; cfg_clk_div = 8'd3;
      wait_g(0, 5);
      chk("R9 oe", mclk_oe, 1);
      chk("R9 fb pins", mclk_o, 4'b0101);
      chk("R9 ch0", raw(0), 4096);
      chk("R9 ch1", raw(1), 0);
      period(0, p);  chk("R9 period A=48", p, 48);
      cfg_dat_pol = 1'b1;
      wait_g(0, 5);
      chk("R9 ch0 inv", raw(0), 0);
      chk("R9 ch1 inv", raw(1), 4096);
      chk("R9 fb pins raw", mclk_o, 4'b0101);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule